// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address front end of a synchronous burst memory. On a rising clock edge it can capture an external word address into an internal base register. A burst counter then walks the two least significant address bits through a four-beat burst. The outputs are the current word address and the index of the current beat.

Two active-low strobes can load a new address. The controller strobe acts on its own. The processor strobe acts only while the active-low chip enable is also asserted. An active-low advance input steps the beat counter by one. While advance is deasserted, the counter and the address hold.

A static select pin picks the burst order:
- Linear: the low bits count up from the loaded start, modulo four.
- Interleaved: the low bits are the start XOR the beat count.

The upper address bits never change during a burst.

All inputs are plain control levels sampled on the clock edge. No data moves through the block, so it has no valid/ready handshake and applies no back-pressure: every strobe and advance is acted on in the cycle it is sampled.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `word_addr` is 0 and `beat_idx` is 0.
- R2: When `ctrl_load_n` is low at a rising edge, `addr_in` is captured whatever the level of `chip_en_n`. From the next cycle, `word_addr` equals the captured address and `beat_idx` is 0.
- R3: When `proc_load_n` is low and `chip_en_n` is low at a rising edge, `addr_in` is captured. `beat_idx` returns to 0.
- R4: When `chip_en_n` is high, a low `proc_load_n` has no effect: `word_addr` and `beat_idx` keep their values.
- R5: With no load, `advance_n` low at an edge increments `beat_idx` by one. `advance_n` high leaves `beat_idx` and `word_addr` unchanged.
- R6: With `order_sel` = 0 (linear), `word_addr[1:0]` equals (start bits + `beat_idx`) mod 4.
- R7: With `order_sel` = 1 (interleaved), `word_addr[1:0]` equals start bits XOR `beat_idx`.
- R8: After four advances, `beat_idx` wraps from 3 to 0. `word_addr[18:2]` never changes except on a load, even when the start address is all ones.
- R9: When a load and `advance_n` low occur at the same edge, the load wins: the new address is taken and `beat_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | 19 | Word address to load |
| ctrl_load_n | input | 1 | Controller load strobe, active low, not gated |
| proc_load_n | input | 1 | Processor load strobe, active low, gated by chip enable |
| chip_en_n | input | 1 | Active-low chip enable that qualifies the processor strobe |
| advance_n | input | 1 | Active-low burst advance |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved; static while running |
| word_addr | output | 19 | Current word address |
| beat_idx | output | 2 | Current beat number in the burst |

## Verification
A load and an advance can land on the same clock edge, and the load must win. The bench provokes this by holding `advance_n` low while pulsing either strobe in the middle of a running burst. It judges the result by expecting the fresh address with beat index 0 rather than an incremented beat. The same situation is repeated with the processor strobe while chip enable is high. In that case the advance must proceed, because the gated strobe does not count as a load.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/load_decode.sv
module load_decode (
  input  logic ctrl_load_n,
  input  logic proc_load_n,
  input  logic chip_en_n,
  output logic load
);
  logic ctrl_hit;
  logic proc_hit;

  always_comb begin
    ctrl_hit = ~ctrl_load_n;
    proc_hit = ~proc_load_n & ~chip_en_n;
    load     = ctrl_hit | proc_hit;
  end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  output logic [BEAT_W-1:0] count
);
  localparam logic [BEAT_W-1:0] LAST = {BEAT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= '0;
    else if (step) count <= count + 1'b1;
  end

  // R9
  load_clears_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == '0);
  // R5
  hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(count));
  // R8
  wrap_at_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && step && count == LAST) |=> count == '0);
endmodule

// File: rtl/order_map.sv
module order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_bits,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] low_bits
);
  logic [BEAT_W-1:0] lin_bits;
  logic [BEAT_W-1:0] ilv_bits;

  genvar b;
  generate
    for (b = 0; b < BEAT_W; b++) begin : g_ilv
      assign ilv_bits[b] = start_bits[b] ^ beat[b];
    end
  endgenerate

  assign lin_bits = start_bits + beat;
  assign low_bits = (order == ORD_INTERLEAVE) ? ilv_bits : lin_bits;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              ctrl_load_n,
  input  logic              proc_load_n,
  input  logic              chip_en_n,
  input  logic              advance_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] word_addr,
  output logic [BEAT_W-1:0] beat_idx
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic              load;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] low_bits;
  burst_order_e      order;

  assign order = burst_order_e'(order_sel);

  load_decode u_dec (
    .ctrl_load_n (ctrl_load_n),
    .proc_load_n (proc_load_n),
    .chip_en_n   (chip_en_n),
    .load        (load)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= addr_in;
  end

  beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (~advance_n),
    .count (beat_idx)
  );

  order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_bits (base_q[BEAT_W-1:0]),
    .beat       (beat_idx),
    .order      (order),
    .low_bits   (low_bits)
  );

  assign word_addr = {base_q[ADDR_W-1:BEAT_W], low_bits};

  // R8
  upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(word_addr[ADDR_W-1:BEAT_W]));
  // R4
  gated_strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_load_n && chip_en_n && advance_n) |=> ($stable(word_addr) && $stable(beat_idx)));
  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_load_n |=> (word_addr == $past(addr_in) && beat_idx == '0));
  // R5
  advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance_n) |=> beat_idx == $past(beat_idx) + 1'b1);
  // R3
  proc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_load_n && !chip_en_n) |=> word_addr == $past(addr_in));
endmodule

// File: tb/test_burst_addr_seq.sv
`timescale 1ns/1ps
module test_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [18:0] addr_in = '0;
  logic        ctrl_load_n = 1'b1, proc_load_n = 1'b1, chip_en_n = 1'b1;
  logic        advance_n = 1'b1, order_sel = 1'b0;
  logic [18:0] word_addr;
  logic [1:0]  beat_idx;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [18:0] addr;
    logic [1:0]  beat;
    string       req;
  } exp_t;
  exp_t sbq[$];

  logic [18:0] m_base = '0;
  logic [1:0]  m_cnt = '0;

  always #5 clk = ~clk;

  burst_addr_seq i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .addr_in(addr_in),
    .ctrl_load_n(ctrl_load_n), .proc_load_n(proc_load_n), .chip_en_n(chip_en_n),
    .advance_n(advance_n), .order_sel(order_sel),
    .word_addr(word_addr), .beat_idx(beat_idx)
  );

  function automatic logic [18:0] model_addr();
    logic [1:0] lo;
    lo = order_sel ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
    return {m_base[18:2], lo};
  endfunction

  task automatic drive(input logic [18:0] a, input logic cl, input logic pl,
                       input logic ce, input logic adv, input string req);
    exp_t e;
    @(negedge clk);
    addr_in = a; ctrl_load_n = cl; proc_load_n = pl; chip_en_n = ce; advance_n = adv;
    if (!cl || (!pl && !ce)) begin
      m_base = a;
      m_cnt = '0;
    end else if (!adv) begin
      m_cnt = m_cnt + 2'd1;
    end
    e.addr = model_addr();
    e.beat = m_cnt;
    e.req = req;
    sbq.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      checks++;
      if (word_addr !== e.addr || beat_idx !== e.beat) begin
        fails++;
        $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                 e.req, word_addr, beat_idx, e.addr, e.beat);
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    checks++;
    if (word_addr !== '0 || beat_idx !== '0) begin
      fails++;
      $display("FAIL R1: addr=%h beat=%0d expected addr=0 beat=0", word_addr, beat_idx);
    end
    rst_n = 1'b1;
    // R2: controller strobe loads even with chip enable high
    drive(19'h2A5F6, 0, 1, 1, 1, "R2");
    // R5, R6, R8: linear walk from start 2 with wrap
    drive(19'h00000, 1, 1, 1, 0, "R6");
    drive(19'h00000, 1, 1, 1, 0, "R6");
    drive(19'h00000, 1, 1, 1, 0, "R6");
    drive(19'h00000, 1, 1, 1, 0, "R8");
    // R5: hold with advance high
    drive(19'h11111, 1, 1, 1, 1, "R5");
    drive(19'h11111, 1, 1, 1, 1, "R5");
    // R3: processor strobe with chip enable low
    drive(19'h12343, 1, 0, 0, 1, "R3");
    drive(19'h00000, 1, 1, 0, 0, "R6");
    // R4: processor strobe with chip enable high is ignored
    drive(19'h7FFFF, 1, 0, 1, 1, "R4");
    drive(19'h55555, 1, 0, 1, 0, "R4");
    // R9: load and advance together
    drive(19'h0ABC1, 0, 1, 1, 0, "R9");
    drive(19'h00000, 1, 1, 1, 0, "R5");
    drive(19'h3C3C2, 1, 0, 0, 0, "R9");
    // R7: interleaved order from start 1 (static change while idle)
    drive(19'h00000, 1, 1, 1, 1, "R5");
    @(negedge clk);
    order_sel = 1'b1;
    drive(19'h44441, 0, 1, 1, 1, "R7");
    for (int i = 0; i < 4; i++) drive(19'h0, 1, 1, 1, 0, "R7");
    // R8: all-ones start, no carry into upper bits in both orders
    drive(19'h7FFFF, 0, 1, 0, 1, "R8");
    for (int i = 0; i < 5; i++) drive(19'h0, 1, 1, 1, 0, "R8");
    @(negedge clk);
    order_sel = 1'b0;
    drive(19'h7FFFF, 1, 0, 0, 1, "R8");
    for (int i = 0; i < 5; i++) drive(19'h0, 1, 1, 1, 0, "R8");
    drive(19'h0, 1, 1, 1, 1, "R5");
    repeat (3) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule